// File: doc/BRIEF.md
# Mode-Banked General Register File

This block holds the sixteen 32-bit general registers of a processor with seven operating modes. Which physical storage word a register index (0 to 15) reaches depends on the mode presented on the mode input. Registers 0 to 7 and register 15 are one copy that every mode shares. The fast-interrupt mode has a private set for registers 8 to 14. The four other exception modes each have a private stack pointer (r13) and link register (r14). Each of the five exception modes also has a saved-status word. System mode reaches exactly the same storage as User mode.

The datapath reads two registers through combinational ports and writes one register per clock. The exception sequencer has a separate side port. In one cycle it loads the link register and the saved-status word of a mode that it names, which need not be the current mode. This can happen in the same cycle as an ordinary register write. The program counter is kept as plain register 15 storage.

Top module: `bankreg_file`

## Requirements
- R1: A clock edge with `rst_n` low clears every physical register and every saved-status word to zero.
- R2: Registers 0–7 and 15 are one copy. A write in any mode is read back at the same index in every mode.
- R3: In fast-interrupt mode (mode code 10001), indices 8–14 reach a private set. In every other mode, indices 8–12 reach the shared copy.
- R4: IRQ (10010), supervisor (10011), abort (10111) and undefined (11011) modes each have their own r13 and r14. These are separate from the User r13/r14.
- R5: System mode (11111) reaches the same registers as User mode (10000).
- R6: Any mode code other than the seven listed is treated as User mode, for register reads, register writes and saved-status access.
- R7: Writes take effect on the rising clock edge. Both read ports are combinational. In a cycle where a read and a write hit the same register, the read returns the value stored before that write.
- R8: In an exception mode, `spsr_rd_data` returns that mode's saved-status word, and `spsr_wr_en` writes it at the clock edge.
- R9: In User or System mode, `spsr_rd_data` equals `cur_status`, and `spsr_wr_en` changes no saved-status word.
- R10: With `exc_wr_en` high, `exc_lr_data` is written to r14 of the mode `exc_mode` selects, and `exc_spsr_data` is written to that mode's saved-status word. If that mode has no saved-status word, only r14 is written. This happens in the same cycle as an ordinary write to a different register.
- R11: If the side port and an ordinary write hit the same physical register or the same saved-status word in one cycle, the side port's value is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| mode | input | 5 | Current operating mode code |
| rd_a_idx | input | 4 | Read port A register index |
| rd_a_data | output | 32 | Read port A data |
| rd_b_idx | input | 4 | Read port B register index |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | Ordinary register write enable |
| wr_idx | input | 4 | Ordinary write register index |
| wr_data | input | 32 | Ordinary write data |
| cur_status | input | 32 | Current status word, returned as saved status in User/System |
| spsr_rd_data | output | 32 | Saved-status word of the current mode |
| spsr_wr_en | input | 1 | Write the current mode's saved-status word |
| spsr_wr_data | input | 32 | Data for the current mode's saved-status word |
| exc_wr_en | input | 1 | Side-port write enable |
| exc_mode | input | 5 | Target mode for the side-port write |
| exc_lr_data | input | 32 | Value for the target mode's r14 |
| exc_spsr_data | input | 32 | Value for the target mode's saved-status word |

## Verification
The hardest situation to reach is a side-port write that targets a bank other than the current one. Its effect shows only after the mode input later moves to that bank, and by then ordinary writes in other modes must not have disturbed it. Collisions between the side port and an ordinary write to the same physical word are also hard to reach. The random stimulus draws the current mode and the side-port target mode independently. It biases indices toward 13 and 14 and switches mode every cycle, so banked words are written in one mode and read many cycles later in another. Directed steps force the exact collision cases and the same-cycle read-before-write case.

// File: rtl/bankreg_pkg.sv
// Shared types for the banked register file.
// Assumes the 5-bit mode codes listed in the brief; unknown codes fold to User.
package bankreg_pkg;

    typedef enum logic [2:0] {
        BK_USR = 3'd0,
        BK_FIQ = 3'd1,
        BK_IRQ = 3'd2,
        BK_SVC = 3'd3,
        BK_ABT = 3'd4,
        BK_UND = 3'd5
    } bank_t;

    localparam int ARCH_REGS    = 16;
    localparam int FIQ_PRIV     = 7;  // r8..r14
    localparam int PAIR_BANKS   = 4;  // IRQ, SVC, ABT, UND
    localparam int SAVED_SLOTS  = 5;  // one per exception mode
    localparam int FIQ_BASE     = ARCH_REGS;
    localparam int PAIR_BASE    = FIQ_BASE + FIQ_PRIV;
    localparam int TOTAL_PHYS   = PAIR_BASE + 2 * PAIR_BANKS;

    // Fold a 5-bit mode code onto its register bank (System shares User).
    function automatic bank_t mode_to_bank(input logic [4:0] code);
        case (code)
            5'b10001: return BK_FIQ;
            5'b10010: return BK_IRQ;
            5'b10011: return BK_SVC;
            5'b10111: return BK_ABT;
            5'b11011: return BK_UND;
            default:  return BK_USR;
        endcase
    endfunction

endpackage

// File: rtl/bankreg_map.sv
// Translates an architectural register index and a bank into a physical
// storage index. Purely combinational; assumes bank is already decoded.
module bankreg_map
    import bankreg_pkg::*;
#(
    parameter int PHYS_W = 5
) (
    input  logic [3:0]        idx,
    input  bank_t             bank,
    output logic [PHYS_W-1:0] phys
);

    // Select the private copy when the bank owns the requested index.
    always_comb begin
        phys = PHYS_W'(idx);
        if (idx >= 4'd8 && idx <= 4'd14) begin
            if (bank == BK_FIQ) begin
                phys = PHYS_W'(FIQ_BASE + int'(idx) - 8);
            end else if (idx >= 4'd13 && bank != BK_USR) begin
                phys = PHYS_W'(PAIR_BASE + 2 * (int'(bank) - int'(BK_IRQ)) + int'(idx) - 13);
            end
        end
    end

endmodule

// File: rtl/bankreg_saved.sv
// Saved-status words, one per exception bank. The side port has priority
// over the current-mode write. Assumes User bank owns no slot.
module bankreg_saved
    import bankreg_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bank_t             cur_bank,
    input  logic [DATA_W-1:0] cur_status,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              exc_en,
    input  bank_t             exc_bank,
    input  logic [DATA_W-1:0] exc_data,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] slot_q [SAVED_SLOTS];

    for (genvar s = 0; s < SAVED_SLOTS; s++) begin : g_slot
        localparam bank_t OWN = bank_t'(s + 1);
        // Update one slot: side port first, then current-mode write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_q[s] <= '0;
            end else if (exc_en && exc_bank == OWN) begin
                slot_q[s] <= exc_data;
            end else if (wr_en && cur_bank == OWN) begin
                slot_q[s] <= wr_data;
            end
        end
    end

    // Current bank's slot, or the live status when the bank has none.
    always_comb begin
        rd_data = cur_status;
        for (int s = 0; s < SAVED_SLOTS; s++) begin
            if (cur_bank == bank_t'(s + 1)) rd_data = slot_q[s];
        end
    end

endmodule

// File: rtl/bankreg_file.sv
// Top of the mode-banked register file: two combinational read ports,
// one write port, and a side port for exception entry that writes r14 and
// the saved status of a named mode. Reads see pre-edge contents.
module bankreg_file
    import bankreg_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [4:0]        mode,
    input  logic [3:0]        rd_a_idx,
    output logic [DATA_W-1:0] rd_a_data,
    input  logic [3:0]        rd_b_idx,
    output logic [DATA_W-1:0] rd_b_data,
    input  logic              wr_en,
    input  logic [3:0]        wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [DATA_W-1:0] cur_status,
    output logic [DATA_W-1:0] spsr_rd_data,
    input  logic              spsr_wr_en,
    input  logic [DATA_W-1:0] spsr_wr_data,
    input  logic              exc_wr_en,
    input  logic [4:0]        exc_mode,
    input  logic [DATA_W-1:0] exc_lr_data,
    input  logic [DATA_W-1:0] exc_spsr_data
);

    localparam int PHYS_W = $clog2(TOTAL_PHYS);

    bank_t cur_bank, exc_bank;
    logic [PHYS_W-1:0] a_phys, b_phys, w_phys, e_phys;
    logic [DATA_W-1:0] store_q [TOTAL_PHYS];

    // Decode both mode codes to banks.
    always_comb begin
        cur_bank = mode_to_bank(mode);
        exc_bank = mode_to_bank(exc_mode);
    end

    bankreg_map #(.PHYS_W(PHYS_W)) map_a_i (.idx(rd_a_idx), .bank(cur_bank), .phys(a_phys));
    bankreg_map #(.PHYS_W(PHYS_W)) map_b_i (.idx(rd_b_idx), .bank(cur_bank), .phys(b_phys));
    bankreg_map #(.PHYS_W(PHYS_W)) map_w_i (.idx(wr_idx),   .bank(cur_bank), .phys(w_phys));
    bankreg_map #(.PHYS_W(PHYS_W)) map_e_i (.idx(4'd14),    .bank(exc_bank), .phys(e_phys));

    for (genvar p = 0; p < TOTAL_PHYS; p++) begin : g_word
        // Update one physical word: side-port link write wins over ordinary write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                store_q[p] <= '0;
            end else if (exc_wr_en && e_phys == PHYS_W'(p)) begin
                store_q[p] <= exc_lr_data;
            end else if (wr_en && w_phys == PHYS_W'(p)) begin
                store_q[p] <= wr_data;
            end
        end
    end

    // Combinational read ports.
    always_comb begin
        rd_a_data = store_q[a_phys];
        rd_b_data = store_q[b_phys];
    end

    bankreg_saved #(.DATA_W(DATA_W)) saved_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cur_bank   (cur_bank),
        .cur_status (cur_status),
        .wr_en      (spsr_wr_en),
        .wr_data    (spsr_wr_data),
        .exc_en     (exc_wr_en),
        .exc_bank   (exc_bank),
        .exc_data   (exc_spsr_data),
        .rd_data    (spsr_rd_data)
    );

endmodule

// File: rtl/bankreg_chk.sv
// Port-level temporal checks for bankreg_file, attached by bind.
// Assumes a synchronous active-low reset held for at least one edge.
module bankreg_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [4:0]        mode,
    input logic [3:0]        rd_a_idx,
    input logic [DATA_W-1:0] rd_a_data,
    input logic [3:0]        rd_b_idx,
    input logic [DATA_W-1:0] rd_b_data,
    input logic              wr_en,
    input logic [3:0]        wr_idx,
    input logic [DATA_W-1:0] wr_data,
    input logic [DATA_W-1:0] cur_status,
    input logic [DATA_W-1:0] spsr_rd_data,
    input logic              exc_wr_en,
    input logic [4:0]        exc_mode,
    input logic [DATA_W-1:0] exc_lr_data,
    input logic [DATA_W-1:0] exc_spsr_data
);

    // R1
    reset_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (rd_a_data == '0 && rd_b_data == '0));

    // R2
    shared_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_en) && $past(wr_idx) < 4'd8 && rd_a_idx == $past(wr_idx))
        |-> rd_a_data == $past(wr_data));

    // R9
    user_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 5'b10000 || mode == 5'b11111) |-> spsr_rd_data == cur_status);

    // R10
    side_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(exc_wr_en) && $past(exc_mode) == 5'b10010
         && mode == 5'b10010 && rd_b_idx == 4'd14)
        |-> rd_b_data == $past(exc_lr_data));

    // R10
    side_saved_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(exc_wr_en) && $past(exc_mode) == 5'b10011 && mode == 5'b10011)
        |-> spsr_rd_data == $past(exc_spsr_data));

endmodule

bind bankreg_file bankreg_chk #(.DATA_W(DATA_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .mode(mode),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .cur_status(cur_status), .spsr_rd_data(spsr_rd_data),
    .exc_wr_en(exc_wr_en), .exc_mode(exc_mode),
    .exc_lr_data(exc_lr_data), .exc_spsr_data(exc_spsr_data)
);

// File: tb/bankreg_file_tb.sv
// Self-checking bench: directed corners plus seeded random traffic,
// compared against a bench-side model of the banking rules.
module bankreg_file_tb_top;

    logic        clk = 0;
    logic        rst_n = 0;
    logic [4:0]  mode = 5'b10000;
    logic [3:0]  rd_a_idx = 0, rd_b_idx = 0, wr_idx = 0;
    logic [31:0] rd_a_data, rd_b_data, spsr_rd_data;
    logic        wr_en = 0, spsr_wr_en = 0, exc_wr_en = 0;
    logic [31:0] wr_data = 0, cur_status = 0, spsr_wr_data = 0;
    logic [4:0]  exc_mode = 5'b10000;
    logic [31:0] exc_lr_data = 0, exc_spsr_data = 0;

    int checks = 0;
    int bad = 0;
    bit done = 0;

    logic [31:0] m_reg [31];
    logic [31:0] m_sav [5];

    always #5 clk = ~clk;

    bankreg_file dut_i (.*);

    // Model: physical word for index in a mode (R3..R6).
    function automatic int m_phys(input logic [3:0] i, input logic [4:0] md);
        int base;
        case (md)
            5'b10001: return (i >= 8 && i <= 14) ? 16 + int'(i) - 8 : int'(i);
            5'b10010: base = 23;
            5'b10011: base = 25;
            5'b10111: base = 27;
            5'b11011: base = 29;
            default:  return int'(i);
        endcase
        return (i == 13 || i == 14) ? base + int'(i) - 13 : int'(i);
    endfunction

    // Model: saved-status slot of a mode, -1 when none (R8, R9).
    function automatic int m_slot(input logic [4:0] md);
        case (md)
            5'b10001: return 0;
            5'b10010: return 1;
            5'b10011: return 2;
            5'b10111: return 3;
            5'b11011: return 4;
            default:  return -1;
        endcase
    endfunction

    function automatic string read_tag(input logic [3:0] i, input logic [4:0] md);
        if (m_slot(md) < 0 && md != 5'b10000 && md != 5'b11111) return "R6";
        if (md == 5'b11111) return "R5";
        if (i < 8 || i == 15) return "R2";
        if (md == 5'b10001 || i < 13) return "R3";
        return "R4";
    endfunction

    function automatic logic [4:0] pick_mode(input int unsigned r);
        case (r % 8)
            0: return 5'b10000;
            1: return 5'b10001;
            2: return 5'b10010;
            3: return 5'b10011;
            4: return 5'b10111;
            5: return 5'b11011;
            6: return 5'b11111;
            default: return 5'b00110;
        endcase
    endfunction

    task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Drive one cycle, check the combinational outputs, then advance the model.
    task automatic step(input logic [4:0] md, input logic [3:0] ra, input logic [3:0] rb,
                        input logic we, input logic [3:0] wi, input logic [31:0] wd,
                        input logic swe, input logic [31:0] sd,
                        input logic ee, input logic [4:0] em, input logic [31:0] el,
                        input logic [31:0] es, input string tag);
        int sl, es_sl;
        logic [31:0] exp_s;
        @(negedge clk);
        mode = md; rd_a_idx = ra; rd_b_idx = rb;
        wr_en = we; wr_idx = wi; wr_data = wd;
        spsr_wr_en = swe; spsr_wr_data = sd;
        exc_wr_en = ee; exc_mode = em; exc_lr_data = el; exc_spsr_data = es;
        cur_status = $urandom;
        #1;
        // R7: reads show the contents held before this cycle's write.
        check(tag == "" ? read_tag(ra, md) : tag, "rd_a", rd_a_data, m_reg[m_phys(ra, md)]);
        check(tag == "" ? read_tag(rb, md) : tag, "rd_b", rd_b_data, m_reg[m_phys(rb, md)]);
        sl = m_slot(md);
        exp_s = (sl < 0) ? cur_status : m_sav[sl];
        check(tag == "" ? (sl < 0 ? "R9" : "R8") : tag, "spsr", spsr_rd_data, exp_s);
        if (we) m_reg[m_phys(wi, md)] = wd;
        if (swe && sl >= 0) m_sav[sl] = sd;
        if (ee) begin
            m_reg[m_phys(4'd14, em)] = el;       // R10, R11: side port last wins
            es_sl = m_slot(em);
            if (es_sl >= 0) m_sav[es_sl] = es;
        end
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        for (int p = 0; p < 31; p++) m_reg[p] = '0;
        for (int s = 0; s < 5; s++) m_sav[s] = '0;
        // Dirty the inputs during reset; nothing may stick (R1).
        wr_en = 1; wr_idx = 4'd3; wr_data = 32'hDEAD_0003;
        repeat (3) @(posedge clk);
        @(negedge clk);
        wr_en = 0; rst_n = 1;

        // R1: everything zero after reset, in shared and banked views.
        step(5'b10000, 4'd0, 4'd15, 0, 0, 0, 0, 0, 0, 5'b10000, 0, 0, "R1");
        step(5'b10001, 4'd8, 4'd14, 0, 0, 0, 0, 0, 0, 5'b10000, 0, 0, "R1");
        // R7: write r5 while reading it; old value then new value.
        step(5'b10000, 4'd5, 4'd5, 1, 4'd5, 32'hA5A5_0005, 0, 0, 0, 5'b10000, 0, 0, "R7");
        step(5'b10010, 4'd5, 4'd0, 0, 0, 0, 0, 0, 0, 5'b10000, 0, 0, "R2");
        // R3: FIQ r8 private, User r8 untouched.
        step(5'b10001, 4'd8, 4'd12, 1, 4'd8, 32'hF1F1_0008, 0, 0, 0, 5'b10000, 0, 0, "R3");
        step(5'b10000, 4'd8, 4'd8, 0, 0, 0, 0, 0, 0, 5'b10000, 0, 0, "R3");
        step(5'b10001, 4'd8, 4'd13, 0, 0, 0, 0, 0, 0, 5'b10000, 0, 0, "R3");
        // R10: side port into IRQ while User writes r3.
        step(5'b10000, 4'd3, 4'd14, 1, 4'd3, 32'h3333_0003, 0, 0, 1, 5'b10010,
             32'h1111_00E1, 32'h5555_00E1, "R10");
        step(5'b10010, 4'd14, 4'd3, 0, 0, 0, 0, 0, 0, 5'b10000, 0, 0, "R10");
        step(5'b10000, 4'd14, 4'd13, 0, 0, 0, 0, 0, 0, 5'b10000, 0, 0, "R4");
        // R11: SVC writes own r14 and spsr while side port hits the same words.
        step(5'b10011, 4'd14, 4'd0, 1, 4'd14, 32'hBAD0_0014, 1, 32'hBAD0_5555, 1, 5'b10011,
             32'h600D_0014, 32'h600D_5555, "R11");
        step(5'b10011, 4'd14, 4'd13, 0, 0, 0, 0, 0, 0, 5'b10000, 0, 0, "R11");
        // R8: abort saved status written and read back.
        step(5'b10111, 4'd0, 4'd1, 0, 0, 0, 1, 32'hAB0A_0001, 0, 5'b10000, 0, 0, "R8");
        step(5'b10111, 4'd0, 4'd1, 0, 0, 0, 0, 0, 0, 5'b10000, 0, 0, "R8");
        // R9: saved-status write in System is ignored; all slots still checked.
        step(5'b11111, 4'd0, 4'd1, 0, 0, 0, 1, 32'h9999_9999, 0, 5'b10000, 0, 0, "R9");
        for (int k = 0; k < 5; k++)
            step(pick_mode(k + 1), 4'd0, 4'd0, 0, 0, 0, 0, 0, 0, 5'b10000, 0, 0, "R9");
        // R5/R6: System and unknown code reach User r13.
        step(5'b10000, 4'd13, 4'd13, 1, 4'd13, 32'h0000_5713, 0, 0, 0, 5'b10000, 0, 0, "R5");
        step(5'b11111, 4'd13, 4'd14, 0, 0, 0, 0, 0, 0, 5'b10000, 0, 0, "R5");
        step(5'b01010, 4'd13, 4'd14, 0, 0, 0, 0, 0, 0, 5'b10000, 0, 0, "R6");

        // Random traffic, indices biased toward banked r13/r14.
        for (int n = 0; n < 3000; n++) begin
            logic [3:0] ra, rb, wi;
            ra = ($urandom % 3 == 0) ? 4'(13 + $urandom % 2) : 4'($urandom);
            rb = ($urandom % 3 == 0) ? 4'(8 + $urandom % 7) : 4'($urandom);
            wi = ($urandom % 2 == 0) ? 4'(8 + $urandom % 7) : 4'($urandom);
            step(pick_mode($urandom), ra, rb, 1'($urandom % 3 != 0), wi, $urandom,
                 1'($urandom % 4 == 0), $urandom, 1'($urandom % 5 == 0), pick_mode($urandom),
                 $urandom, $urandom, "");
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule